// File: doc/BRIEF.md
# Power-Down Retention Controller

This block sequences a small microcontroller into and out of a low-power state in which the RAM array keeps its contents. Software reaches that state in two steps. First it retires an arm instruction. The very next retired instruction must then be one of two power-off instructions. In the power-down state the oscillator is held stopped and every port output level is frozen. The one exception is the port C latch on the shared pin, which is forced to 1 as the state is entered.

The two power-off variants differ in one way only. Variant A leaves the supply-drop detector running, so a supply drop during power-down forces a full system reset. Variant B switches the detector off.

A wake event starts the oscillator again and waits a fixed settle time. The block then raises one-cycle clear strobes for the state groups that must restart from their initial values: the CPU core group, the primary timer and clock control group, the interrupt group and the watchdog group. In the same cycle it loads the stack pointer with its top value. After that it releases the CPU. Groups that receive no strobe keep their contents: the secondary timer controls, pull-up, key-wake, converter and third interrupt controls, and the port D2 latch. A status bit tells software whether the last restart came from a wake or from a cold or supply-drop reset.

States: RUN (CPU executing), ENTER (one entry cycle that sets port C), DOWN (oscillator stopped), SETTLE (oscillator running, waiting), CLEAR (strobe cycle), RST (supply-drop reset pulse).

Transitions:
- RUN→ENTER on an armed power-off.
- ENTER→DOWN always.
- DOWN→SETTLE on wake.
- SETTLE→CLEAR when the count ends.
- CLEAR→RUN always.
- RST→RUN always.
- Any state→RST on a supply drop while the detector is enabled.

Top module: `pdn_ctrl`

## Requirements
- R1: Instructions are coded on `instr_kind` as 0 other, 1 arm, 2 power-off A and 3 power-off B, and count only when `instr_vld` is high in RUN. A power-off enters power-down only if the previous valid instruction was an arm. Otherwise it is ignored: `cpu_run` stays 1 and `osc_stop` stays 0.
- R2: Power-down entry takes one ENTER cycle with `portc_set`=1, `osc_stop`=1, `port_hold`=1 and `cpu_run`=0. It is followed by DOWN, where `osc_stop` and `port_hold` stay 1 and `portc_set` is 0.
- R3: `det_en` is 0 in ENTER and DOWN of variant B and 1 in every other state.
- R4: `vdrop`=1 while `det_en`=1 gives one RST cycle with `sys_rst_req`=1, `osc_stop`=0 and `cpu_run`=0, then RUN. This has priority over every other transition. `vdrop` while `det_en`=0 has no effect.
- R5: `wake_evt` in DOWN clears `osc_stop` in the next cycle and keeps `cpu_run` at 0 for exactly 16 SETTLE cycles. `wake_evt` in any other state has no effect.
- R6: After SETTLE there is exactly one CLEAR cycle. In it `clr_cpu`, `clr_tmr`, `clr_irq`, `clr_wdt` and `sp_load` are 1 and `sp_val` is 7. The strobes are 0 in every other cycle, and `cpu_run` is 1 in the following cycle.
- R7: `warm_boot` is 0 after `rst_n` reset, becomes 1 after a CLEAR cycle and returns to 0 when RST is entered.
- R8: While `rst_n` is low the block is in RUN: `cpu_run`=1, `det_en`=1, and all other outputs are 0 with the arm forgotten.
- R9: Leaving RUN forgets the arm, and instructions seen outside RUN are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low cold reset |
| instr_vld | input | 1 | An instruction retires this cycle |
| instr_kind | input | 2 | Retired instruction kind (0 other, 1 arm, 2 off A, 3 off B) |
| wake_evt | input | 1 | Decoded wake request |
| vdrop | input | 1 | Supply-drop detect |
| osc_stop | output | 1 | Stop the oscillator |
| det_en | output | 1 | Supply-drop detector enable |
| port_hold | output | 1 | Freeze port output levels |
| portc_set | output | 1 | Set port C output latch to 1 |
| cpu_run | output | 1 | CPU may execute |
| clr_cpu | output | 1 | Clear PC, accumulator, second register, carry, stack pointer |
| clr_tmr | output | 1 | Clear primary timer control and clock control |
| clr_irq | output | 1 | Clear interrupt controls 1-2, enable flag, request flags, conversion-done flag |
| clr_wdt | output | 1 | Clear watchdog enable, flag and counter |
| sp_load | output | 1 | Load stack pointer with `sp_val` |
| sp_val | output | 3 | Value forced into the stack pointer |
| sys_rst_req | output | 1 | Full system reset request |
| warm_boot | output | 1 | Last restart was a wake from power-down |

## Verification
The checker watches, on every cycle, the properties that are local in time. An oscillator stop must be preceded by a power-off instruction. The port C set lasts one cycle and leads into power-down. A disabled detector is only seen with the oscillator stopped. A supply drop with the detector on yields a reset pulse, and a wake stops the oscillator hold at once. The clear strobe is single and is followed by a running CPU, and a reset request clears the warm flag. The need for the arm to come directly before the power-off, the exact 16-cycle settle length and which variant disables the detector depend on history. Only the bench can show these, by comparing every output each cycle against its own model over directed and random instruction, wake and drop streams.

// File: rtl/pdn_pkg.sv
package pdn_pkg;

    typedef enum logic [2:0] {
        ST_RUN    = 3'd0,
        ST_ENTER  = 3'd1,
        ST_DOWN   = 3'd2,
        ST_SETTLE = 3'd3,
        ST_CLEAR  = 3'd4,
        ST_RST    = 3'd5
    } pdn_state_e;

    typedef enum logic [1:0] {
        K_OTHER = 2'd0,
        K_ARM   = 2'd1,
        K_OFF_A = 2'd2,
        K_OFF_B = 2'd3
    } instr_kind_e;

endpackage

// File: rtl/pdn_arm_flag.sv
module pdn_arm_flag
    import pdn_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       running,
    input  logic       instr_vld,
    input  logic [1:0] instr_kind,
    output logic       off_req,
    output logic       off_var_b
);

    logic armed_q;
    logic is_arm;
    logic is_off;

    assign is_arm    = (instr_kind == K_ARM);
    assign is_off    = (instr_kind == K_OFF_A) || (instr_kind == K_OFF_B);
    assign off_req   = running && instr_vld && is_off && armed_q;
    assign off_var_b = (instr_kind == K_OFF_B);

    // armed only while the latest retired instruction was an arm
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (!running) begin
            armed_q <= 1'b0;
        end else if (instr_vld) begin
            armed_q <= is_arm;
        end
    end

endmodule

// File: rtl/pdn_settle_cnt.sv
module pdn_settle_cnt #(
    parameter int SETTLE_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic done
);

    localparam int CW = (SETTLE_CYC > 2) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

    logic [CW-1:0] cnt_q;

    assign done = active && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!active || done) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/pdn_fsm.sv
module pdn_fsm
    import pdn_pkg::*;
#(
    parameter int              SP_W   = 3,
    parameter logic [SP_W-1:0] SP_TOP = '1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            off_req,
    input  logic            off_var_b,
    input  logic            wake_evt,
    input  logic            vdrop,
    input  logic            settle_done,
    output logic            running,
    output logic            settling,
    output logic            osc_stop,
    output logic            det_en,
    output logic            port_hold,
    output logic            portc_set,
    output logic            clr_all,
    output logic [SP_W-1:0] sp_val,
    output logic            sys_rst_req,
    output logic            warm_boot
);

    pdn_state_e state_q, state_d;
    logic       var_b_q;
    logic       warm_q;
    logic       drop_hit;

    assign drop_hit = vdrop && det_en;

    always_comb begin
        state_d = state_q;
        if (drop_hit) begin
            state_d = ST_RST;
        end else begin
            unique case (state_q)
                ST_RUN:    if (off_req) state_d = ST_ENTER;
                ST_ENTER:  state_d = ST_DOWN;
                ST_DOWN:   if (wake_evt) state_d = ST_SETTLE;
                ST_SETTLE: if (settle_done) state_d = ST_CLEAR;
                ST_CLEAR:  state_d = ST_RUN;
                ST_RST:    state_d = ST_RUN;
                default:   state_d = ST_RUN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            var_b_q <= 1'b0;
            warm_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_RUN && off_req) begin
                var_b_q <= off_var_b;
            end
            if (state_d == ST_RST) begin
                warm_q <= 1'b0;
            end else if (state_q == ST_CLEAR) begin
                warm_q <= 1'b1;
            end
        end
    end

    always_comb begin
        running     = 1'b0;
        settling    = 1'b0;
        osc_stop    = 1'b0;
        det_en      = 1'b1;
        port_hold   = 1'b0;
        portc_set   = 1'b0;
        clr_all     = 1'b0;
        sys_rst_req = 1'b0;
        unique case (state_q)
            ST_RUN:    running = 1'b1;
            ST_ENTER: begin
                osc_stop  = 1'b1;
                port_hold = 1'b1;
                portc_set = 1'b1;
                det_en    = !var_b_q;
            end
            ST_DOWN: begin
                osc_stop  = 1'b1;
                port_hold = 1'b1;
                det_en    = !var_b_q;
            end
            ST_SETTLE: settling    = 1'b1;
            ST_CLEAR:  clr_all     = 1'b1;
            ST_RST:    sys_rst_req = 1'b1;
            default:   running     = 1'b0;
        endcase
    end

    assign sp_val    = clr_all ? SP_TOP : '0;
    assign warm_boot = warm_q;

endmodule

// File: rtl/pdn_ctrl.sv
module pdn_ctrl #(
    parameter int SETTLE_CYC = 16,
    parameter int SP_W       = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            instr_vld,
    input  logic [1:0]      instr_kind,
    input  logic            wake_evt,
    input  logic            vdrop,
    output logic            osc_stop,
    output logic            det_en,
    output logic            port_hold,
    output logic            portc_set,
    output logic            cpu_run,
    output logic            clr_cpu,
    output logic            clr_tmr,
    output logic            clr_irq,
    output logic            clr_wdt,
    output logic            sp_load,
    output logic [SP_W-1:0] sp_val,
    output logic            sys_rst_req,
    output logic            warm_boot
);

    localparam logic [SP_W-1:0] SP_TOP = '1;

    logic running;
    logic settling;
    logic off_req;
    logic off_var_b;
    logic settle_done;
    logic clr_all;

    pdn_arm_flag u_arm (
        .clk        (clk),
        .rst_n      (rst_n),
        .running    (running),
        .instr_vld  (instr_vld),
        .instr_kind (instr_kind),
        .off_req    (off_req),
        .off_var_b  (off_var_b)
    );

    pdn_settle_cnt #(.SETTLE_CYC(SETTLE_CYC)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (settling),
        .done   (settle_done)
    );

    pdn_fsm #(.SP_W(SP_W), .SP_TOP(SP_TOP)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .off_req     (off_req),
        .off_var_b   (off_var_b),
        .wake_evt    (wake_evt),
        .vdrop       (vdrop),
        .settle_done (settle_done),
        .running     (running),
        .settling    (settling),
        .osc_stop    (osc_stop),
        .det_en      (det_en),
        .port_hold   (port_hold),
        .portc_set   (portc_set),
        .clr_all     (clr_all),
        .sp_val      (sp_val),
        .sys_rst_req (sys_rst_req),
        .warm_boot   (warm_boot)
    );

    assign cpu_run = running;
    assign clr_cpu = clr_all;
    assign clr_tmr = clr_all;
    assign clr_irq = clr_all;
    assign clr_wdt = clr_all;
    assign sp_load = clr_all;

endmodule

// File: rtl/pdn_ctrl_chk.sv
module pdn_ctrl_chk #(
    parameter int SP_W = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            instr_vld,
    input logic [1:0]      instr_kind,
    input logic            wake_evt,
    input logic            vdrop,
    input logic            osc_stop,
    input logic            det_en,
    input logic            portc_set,
    input logic            cpu_run,
    input logic            clr_cpu,
    input logic            sys_rst_req,
    input logic            warm_boot,
    input logic [SP_W-1:0] sp_val
);

    AST_STOP_AFTER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(osc_stop) |-> $past(instr_vld && instr_kind[1] && cpu_run)); // R1

    AST_PORTC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        portc_set |=> (!portc_set && (osc_stop || sys_rst_req))); // R2

    AST_DET_OFF_ONLY_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        !det_en |-> (osc_stop && !cpu_run)); // R3

    AST_DROP_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
        (det_en && vdrop && !sys_rst_req) |=> (sys_rst_req && !osc_stop && !cpu_run)); // R4

    AST_WAKE_RESTARTS_OSC: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_stop && !portc_set && wake_evt && !(det_en && vdrop)) |=> (!osc_stop && !cpu_run)); // R5

    AST_CLEAR_THEN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_cpu && !vdrop) |=> (!clr_cpu && cpu_run)); // R6

    AST_SP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        clr_cpu |-> (sp_val == {SP_W{1'b1}})); // R6

    AST_RST_COLD: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |=> !warm_boot); // R7

endmodule

bind pdn_ctrl pdn_ctrl_chk #(.SP_W(SP_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_vld   (instr_vld),
    .instr_kind  (instr_kind),
    .wake_evt    (wake_evt),
    .vdrop       (vdrop),
    .osc_stop    (osc_stop),
    .det_en      (det_en),
    .portc_set   (portc_set),
    .cpu_run     (cpu_run),
    .clr_cpu     (clr_cpu),
    .sys_rst_req (sys_rst_req),
    .warm_boot   (warm_boot),
    .sp_val      (sp_val)
);

// File: tb/tb_pdn_ctrl.sv
`timescale 1ns/1ps
module tb_pdn_ctrl;

    localparam int SETTLE = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       instr_vld = 1'b0;
    logic [1:0] instr_kind = 2'd0;
    logic       wake_evt = 1'b0;
    logic       vdrop = 1'b0;
    logic       osc_stop, det_en, port_hold, portc_set, cpu_run;
    logic       clr_cpu, clr_tmr, clr_irq, clr_wdt, sp_load;
    logic [2:0] sp_val;
    logic       sys_rst_req, warm_boot;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    // model: 0 run, 1 enter, 2 down, 3 settle, 4 clear, 5 rst
    int m_st = 0;
    int m_cnt = 0;
    bit m_arm = 0;
    bit m_varb = 0;
    bit m_warm = 0;

    always #4 clk = ~clk;

    pdn_ctrl dut (
        .clk(clk), .rst_n(rst_n), .instr_vld(instr_vld), .instr_kind(instr_kind),
        .wake_evt(wake_evt), .vdrop(vdrop), .osc_stop(osc_stop), .det_en(det_en),
        .port_hold(port_hold), .portc_set(portc_set), .cpu_run(cpu_run),
        .clr_cpu(clr_cpu), .clr_tmr(clr_tmr), .clr_irq(clr_irq), .clr_wdt(clr_wdt),
        .sp_load(sp_load), .sp_val(sp_val), .sys_rst_req(sys_rst_req), .warm_boot(warm_boot)
    );

    function automatic bit exp_det();
        return !((m_st == 1 || m_st == 2) && m_varb);
    endfunction

    function automatic bit exp_clr();
        return m_st == 4;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s cycle=%0d actual=%0d expected=%0d state=%0d", tag, cycles, act, exp, m_st);
        end
    endtask

    task automatic compare_all();
        chk("R1/R8 cpu_run", cpu_run, m_st == 0);
        chk("R2 osc_stop", osc_stop, m_st == 1 || m_st == 2);
        chk("R2 port_hold", port_hold, m_st == 1 || m_st == 2);
        chk("R2 portc_set", portc_set, m_st == 1);
        chk("R3 det_en", det_en, exp_det());
        chk("R4 sys_rst_req", sys_rst_req, m_st == 5);
        chk("R6 clr_cpu", clr_cpu, exp_clr());
        chk("R6 clr_tmr", clr_tmr, exp_clr());
        chk("R6 clr_irq", clr_irq, exp_clr());
        chk("R6 clr_wdt", clr_wdt, exp_clr());
        chk("R6 sp_load", sp_load, exp_clr());
        if (m_st == 4) chk("R6 sp_val", sp_val, 7);
        chk("R7 warm_boot", warm_boot, m_warm);
    endtask

    // advance the model with the inputs applied during this cycle
    task automatic model_step();
        bit drop;
        drop = vdrop && exp_det();
        if (drop) begin
            m_st = 5; m_warm = 0; m_arm = 0;
        end else begin
            case (m_st)
                0: if (instr_vld) begin
                       if (instr_kind[1] && m_arm) begin
                           m_st = 1; m_varb = instr_kind[0]; m_arm = 0;
                       end else begin
                           m_arm = (instr_kind == 2'd1);
                       end
                   end
                1: m_st = 2;
                2: if (wake_evt) begin m_st = 3; m_cnt = 0; end
                3: if (m_cnt == SETTLE - 1) m_st = 4; else m_cnt++;
                4: begin m_st = 0; m_warm = 1; end
                default: m_st = 0;
            endcase
        end
    endtask

    task automatic cyc(input bit v, input logic [1:0] k, input bit w, input bit d);
        instr_vld = v; instr_kind = k; wake_evt = w; vdrop = d;
        @(posedge clk);
        model_step();
        @(negedge clk);
        cycles++;
        compare_all();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 2'd0, 0, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : stim
        int seed;
        seed = 32'h5eed;
        void'($urandom(seed));
        // R8 reset state
        repeat (3) @(negedge clk);
        compare_all();
        chk("R8 det_en in reset", det_en, 1);
        rst_n = 1'b1;
        idle(2);

        // R1 off without arm is ignored
        cyc(1, 2'd2, 0, 0);
        chk("R1 unarmed off ignored", cpu_run, 1);
        // R1 arm, other, off -> ignored
        cyc(1, 2'd1, 0, 0); cyc(1, 2'd0, 0, 0); cyc(1, 2'd3, 0, 0);
        chk("R1 arm broken by other instr", osc_stop, 0);
        // R5 wake while running ignored
        cyc(0, 2'd0, 1, 0);
        chk("R5 wake in run ignored", cpu_run, 1);

        // R1/R2/R5/R6 variant A full cycle, arm with gap cycles (no valid instr)
        cyc(1, 2'd1, 0, 0); idle(2); cyc(1, 2'd2, 0, 0);
        chk("R2 entry portc_set", portc_set, 1);
        idle(3);
        chk("R3 variant A detector on", det_en, 1);
        cyc(1, 2'd1, 0, 0); // R9 instructions while down ignored
        cyc(0, 2'd0, 1, 0);
        for (int i = 0; i < SETTLE; i++) begin
            chk("R5 held during settle", cpu_run, 0);
            if (i < SETTLE - 1) idle(1);
        end
        idle(1);
        chk("R6 clear strobe", clr_cpu, 1);
        idle(1);
        chk("R7 warm after wake", warm_boot, 1);

        // R3/R4 variant B: drop ignored, then wake
        cyc(1, 2'd1, 0, 0); cyc(1, 2'd3, 0, 0);
        cyc(0, 2'd0, 0, 1);
        chk("R3 variant B detector off", det_en, 0);
        chk("R4 drop ignored in B", sys_rst_req, 0);
        cyc(0, 2'd0, 1, 0);
        idle(SETTLE + 2);

        // R4 drop in variant A down
        cyc(1, 2'd1, 0, 0); cyc(1, 2'd2, 0, 0); idle(2);
        cyc(0, 2'd0, 1, 1);
        chk("R4 drop beats wake", sys_rst_req, 1);
        idle(1);
        chk("R7 warm cleared by drop", warm_boot, 0);

        // random phase
        for (int n = 0; n < 6000; n++) begin
            bit v, w, d;
            logic [1:0] k;
            v = ($urandom % 2) == 0;
            k = 2'($urandom % 4);
            w = ($urandom % 12) == 0;
            d = ($urandom % 60) == 0;
            cyc(v, k, w, d);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule